// File: doc/BRIEF.md
# Two-Output Interrupt Controller with Per-Line Trigger Modes

The block takes 51 synchronous interrupt lines and turns them into two request outputs: a normal interrupt request and a fast interrupt request. Each line is either level sensitive or edge sensitive. A level line follows its input, either as is or inverted. An edge line latches a sticky pending bit on a rising edge, on a falling edge, or on any change. The pending bits form a raw status vector. An enable vector masks the raw vector, and a select vector steers each enabled line to one of the two outputs.

Software reaches the block through a plain 32-bit register port. The port has a byte address, a write strobe, write data and combinationally decoded read data, so each access takes one cycle. Every 51-bit vector is split into two words. Byte address bit 2 picks the word: the low word holds bits 31..0, and the high word holds bits 50..32 right-aligned. The register bank starts at byte address 0x80. Enable bits and edge pending bits are changed with separate write-one-to-set and write-one-to-clear words, so software never has to read, modify and write them back.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, raw, enable and select are all zero and both outputs are low. The sensitivity vector reads 0x1F07FFF8FFFF, the dual-edge vector reads 0xF800070000 and the polarity vector reads 0x5F07FFF8FFFF.
- R2: For every vector, the word at bank offset +0 returns bits 31..0. The word at +4 returns bits 50..32 in data bits 18..0, with the upper data bits zero. High-word write data above bit 18 is discarded.
- R3: A read at any byte address below 0x80 returns zero, and a write there changes no state.
- R4: A 1 written at bank offset 0x20/0x24 sets that enable bit, and a 1 written at 0x28/0x2C clears it. Zero bits leave the enable bit alone. Reading 0x20/0x24 returns the enable vector.
- R5: Select at 0x18/0x1C is read/write. A write replaces only the addressed word. A select bit of 1 routes the line to the fast output, and 0 routes it to the normal output.
- R6: A line whose sensitivity bit is 1 has its raw bit (read at 0x10/0x14) equal to its input, or to the inverted input when its polarity bit is 0, one clock after the input is sampled.
- R7: A line whose sensitivity bit is 0 and whose dual-edge bit is 0 sets its raw bit on a rising edge when its polarity bit is 1, or on a falling edge when its polarity bit is 0. The raw bit stays set after the input returns.
- R8: An edge line whose dual-edge bit is 1 sets its raw bit on either input transition.
- R9: A 1 written at 0x58/0x5C clears the raw bit of an edge line but has no effect on a level line. If a new edge arrives in the same cycle as the clear, the raw bit stays set. Reading 0x60/0x64 returns raw AND NOT sensitivity.
- R10: Only polarity bits 47..50 are writable, and only through a high-word write at 0x54, which copies data bits 18..15 into them. A write at 0x50 is ignored. The new polarity takes effect on that line's edge detection.
- R11: The normal output is the OR of raw AND enable AND NOT select, and the fast output is the OR of raw AND enable AND select. Both outputs are registered, so they follow the status one clock later. The same two masked vectors read at 0x00/0x04 and 0x08/0x0C.
- R12: The write-only words 0x28, 0x38 and 0x58, the software-interrupt word 0x30 and undefined offsets all read as zero. Writes to the software-interrupt words, to read-only words (including sensitivity at 0x40) and to undefined offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_i | input | 51 | Interrupt input lines, already synchronous |
| addr_i | input | 12 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe; the write takes effect at the next clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, decoded combinationally |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Inputs and register writes are applied at a falling edge, and the registers they affect update at the next rising edge. A raw, enable, select or polarity change is therefore readable on the port at the following falling edge, and the bench reads it there. The two request outputs pass through one more register, so they are due one rising edge later than the status they reflect. The bench checks that each output is still at its old value at the first falling edge and at its new value at the second. The edge-versus-clear race is produced by applying the input edge and the clear write in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LINES  = 51;
    localparam int WORD_W = 32;
    localparam int HI_W   = LINES - WORD_W;

    localparam logic [63:0] SENSE_RST64 = 64'h0000_1F07_FFF8_FFFF;
    localparam logic [63:0] DUAL_RST64  = 64'h0000_00F8_0007_0000;
    localparam logic [63:0] POL_RST64   = 64'h0000_5F07_FFF8_FFFF;
    localparam logic [63:0] POL_WR64    = 64'h0007_8000_0000_0000;

    localparam int BANK_BASE = 'h80;

    // word offsets inside the bank, bit 2 removed
    localparam int OFF_IRQ_ST  = 'h00;
    localparam int OFF_FIQ_ST  = 'h08;
    localparam int OFF_RAW     = 'h10;
    localparam int OFF_SEL     = 'h18;
    localparam int OFF_EN_SET  = 'h20;
    localparam int OFF_EN_CLR  = 'h28;
    localparam int OFF_SW_SET  = 'h30;
    localparam int OFF_SW_CLR  = 'h38;
    localparam int OFF_SENSE   = 'h40;
    localparam int OFF_DUAL    = 'h48;
    localparam int OFF_POL     = 'h50;
    localparam int OFF_EDGE_CL = 'h58;
    localparam int OFF_EDGE_ST = 'h60;

    typedef struct packed {
        logic [LINES-1:0] sense;
        logic [LINES-1:0] dual;
        logic [LINES-1:0] pol;
    } line_cfg_t;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_EDGE1 = 2'd1,
        TRIG_EDGE2 = 2'd2
    } trig_kind_e;

    function automatic trig_kind_e trig_kind(input logic sense, input logic dual);
        if (sense)     return TRIG_LEVEL;
        else if (dual) return TRIG_EDGE2;
        else           return TRIG_EDGE1;
    endfunction

    function automatic logic edge_seen(input trig_kind_e kind, input logic prev,
                                       input logic cur, input logic pol);
        case (kind)
            TRIG_EDGE2: return prev ^ cur;
            TRIG_EDGE1: return pol ? (~prev & cur) : (prev & ~cur);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] sense_i,
    input  logic [N-1:0] dual_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] raw_o
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic       prev_q;
        logic       raw_q;
        trig_kind_e kind;

        assign kind = trig_kind(sense_i[i], dual_i[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                raw_q  <= 1'b0;
            end else begin
                prev_q <= lines_i[i];
                if (kind == TRIG_LEVEL)
                    raw_q <= pol_i[i] ? lines_i[i] : ~lines_i[i];
                else
                    raw_q <= (raw_q & ~clr_i[i]) |
                             edge_seen(kind, prev_q, lines_i[i], pol_i[i]);
            end
        end

        assign raw_o[i] = raw_q;
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int N  = LINES,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [31:0]   wdata_i,
    input  logic [N-1:0]  raw_i,
    output line_cfg_t     cfg_o,
    output logic [N-1:0]  enable_o,
    output logic [N-1:0]  select_o,
    output logic [N-1:0]  clr_o,
    output logic [31:0]   rdata_o
);

    localparam int HW = N - WORD_W;
    localparam logic [N-1:0] SENSE_RST = SENSE_RST64[N-1:0];
    localparam logic [N-1:0] DUAL_RST  = DUAL_RST64[N-1:0];
    localparam logic [N-1:0] POL_RST   = POL_RST64[N-1:0];
    localparam logic [N-1:0] POL_WR    = POL_WR64[N-1:0];
    localparam logic [N-1:0] HI_HALF   = {{HW{1'b1}}, {WORD_W{1'b0}}};

    logic          in_bank;
    logic          hi;
    logic [AW-1:0] off;
    logic [AW-1:0] woff;
    logic [N-1:0]  wvec;
    logic [N-1:0]  half;
    logic [N-1:0]  en_q, sel_q, pol_q;
    logic [N-1:0]  rvec;
    logic          wr;

    assign in_bank = (addr_i >= AW'(BANK_BASE));
    assign off     = addr_i - AW'(BANK_BASE);
    assign hi      = addr_i[2];
    assign woff    = off & ~AW'(4);
    assign wr      = wr_en_i & in_bank;
    assign half    = hi ? HI_HALF : ~HI_HALF;

    always_comb begin
        wvec = '0;
        if (hi) wvec[N-1:WORD_W] = wdata_i[HW-1:0];
        else    wvec[WORD_W-1:0] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
            pol_q <= POL_RST;
        end else if (wr) begin
            case (woff)
                AW'(OFF_EN_SET): en_q  <= en_q | wvec;
                AW'(OFF_EN_CLR): en_q  <= en_q & ~wvec;
                AW'(OFF_SEL):    sel_q <= (sel_q & ~half) | wvec;
                AW'(OFF_POL):    if (hi) pol_q <= (pol_q & ~POL_WR) | (wvec & POL_WR);
                default: ;
            endcase
        end
    end

    assign clr_o = (wr && woff == AW'(OFF_EDGE_CL)) ? wvec : '0;

    assign cfg_o.sense = SENSE_RST;
    assign cfg_o.dual  = DUAL_RST;
    assign cfg_o.pol   = pol_q;
    assign enable_o    = en_q;
    assign select_o    = sel_q;

    always_comb begin
        case (woff)
            AW'(OFF_IRQ_ST):  rvec = raw_i & en_q & ~sel_q;
            AW'(OFF_FIQ_ST):  rvec = raw_i & en_q & sel_q;
            AW'(OFF_RAW):     rvec = raw_i;
            AW'(OFF_SEL):     rvec = sel_q;
            AW'(OFF_EN_SET):  rvec = en_q;
            AW'(OFF_SENSE):   rvec = SENSE_RST;
            AW'(OFF_DUAL):    rvec = DUAL_RST;
            AW'(OFF_POL):     rvec = pol_q;
            AW'(OFF_EDGE_ST): rvec = raw_i & ~SENSE_RST;
            default:          rvec = '0;
        endcase
        if (!in_bank)  rdata_o = '0;
        else if (hi)   rdata_o = {{(WORD_W-HW){1'b0}}, rvec[N-1:WORD_W]};
        else           rdata_o = rvec[WORD_W-1:0];
    end

endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int N = 51
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] enable_i,
    input  logic [N-1:0] select_i,
    output logic         irq_o,
    output logic         fiq_o
);

    logic [N-1:0] live;
    assign live = raw_i & enable_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(live & ~select_i);
            fiq_o <= |(live & select_i);
        end
    end

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
    import irqc_pkg::*;
#(
    parameter int NL = LINES,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] lines_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o,
    output logic          irq_o,
    output logic          fiq_o
);

    line_cfg_t     cfg;
    logic [NL-1:0] raw;
    logic [NL-1:0] enable;
    logic [NL-1:0] select;
    logic [NL-1:0] clr;

    irqc_regfile #(.N(NL), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .raw_i(raw), .cfg_o(cfg), .enable_o(enable),
        .select_o(select), .clr_o(clr), .rdata_o(rdata_o)
    );

    irqc_detect #(.N(NL)) u_det (
        .clk(clk), .rst(rst), .lines_i(lines_i), .sense_i(cfg.sense),
        .dual_i(cfg.dual), .pol_i(cfg.pol), .clr_i(clr), .raw_o(raw)
    );

    irqc_route #(.N(NL)) u_route (
        .clk(clk), .rst(rst), .raw_i(raw), .enable_i(enable),
        .select_i(select), .irq_o(irq_o), .fiq_o(fiq_o)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NL = 51,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [NL-1:0] lines_i,
    input logic [AW-1:0] addr_i,
    input logic [31:0]   rdata_o,
    input logic          irq_o,
    input logic          fiq_o,
    input logic [NL-1:0] raw,
    input logic [NL-1:0] enable,
    input logic [NL-1:0] select,
    input logic [NL-1:0] clr,
    input logic [NL-1:0] sense,
    input logic [NL-1:0] pol
);

    p_irq_delay_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |($past(raw) & $past(enable) & ~$past(select))));

    p_fiq_delay_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fiq_o == |($past(raw) & $past(enable) & $past(select))));

    p_level_track_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((raw ^ ($past(lines_i) ~^ $past(pol))) & sense) == '0));

    p_edge_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(raw) & ~$past(sense) & ~$past(clr)) & ~raw) == '0));

    p_legacy_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_i < AW'('h80)) |-> (rdata_o == 32'd0));

    p_wo_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (addr_i == AW'('hA8) || addr_i == AW'('hD8) || addr_i == AW'('hB0)) |-> (rdata_o == 32'd0));

endmodule

bind irq_fiq_ctrl irqc_chk #(.NL(NL), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .lines_i(lines_i), .addr_i(addr_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o), .raw(raw),
    .enable(enable), .select(select), .clr(clr), .sense(cfg.sense),
    .pol(cfg.pol)
);

// File: tb/irq_fiq_ctrl_tb.sv
module irq_fiq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [50:0] lines = '0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_fiq_ctrl u_dut (
        .clk(clk), .rst(rst), .lines_i(lines), .addr_i(addr),
        .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clean();
        lines = '0;
        tick(); tick();
        wr(12'hA8, 32'hFFFF_FFFF); wr(12'hAC, 32'hFFFF_FFFF);
        wr(12'h98, 32'h0);         wr(12'h9C, 32'h0);
        wr(12'hD8, 32'hFFFF_FFFF); wr(12'hDC, 32'hFFFF_FFFF);
        tick();
    endtask

    task automatic t_reset();
        rchk("R1 sense lo", 12'hC0, 32'hFFF8_FFFF);
        rchk("R1 sense hi", 12'hC4, 32'h0000_1F07);
        rchk("R1 dual lo",  12'hC8, 32'h0007_0000);
        rchk("R1 dual hi",  12'hCC, 32'h0000_00F8);
        rchk("R1 pol lo",   12'hD0, 32'hFFF8_FFFF);
        rchk("R1 pol hi",   12'hD4, 32'h0000_5F07);
        rchk("R1 raw lo",   12'h90, 32'h0);
        rchk("R1 enable",   12'hA0, 32'h0);
        rchk("R1 select",   12'h98, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 fiq", {31'b0, fiq}, 32'h0);
    endtask

    task automatic t_enable_split();
        clean();
        wr(12'hA4, 32'hFFFF_FFFF);
        rchk("R2 high word masked", 12'hA4, 32'h0007_FFFF);
        wr(12'hA0, 32'h0000_00F0);
        wr(12'hA8, 32'h0000_0030);
        rchk("R4 set then clear", 12'hA0, 32'h0000_00C0);
        wr(12'hAC, 32'h0000_0001);
        rchk("R4 high clear", 12'hA4, 32'h0007_FFFE);
    endtask

    task automatic t_level();
        clean();
        wr(12'hA0, 32'h1);
        lines[0] = 1'b1;
        tick();
        rchk("R6 level raw follows", 12'h90, 32'h1);
        chk("R11 irq not yet", {31'b0, irq}, 32'h0);
        tick();
        chk("R11 irq one clock later", {31'b0, irq}, 32'h1);
        rchk("R11 irq status read", 12'h80, 32'h1);
        rchk("R9 level not in edge status", 12'hE0, 32'h0);
        wr(12'hD8, 32'h1);
        rchk("R9 clear ignores level line", 12'h90, 32'h1);
        wr(12'h98, 32'h1);
        tick();
        chk("R5 routed to fiq", {31'b0, fiq}, 32'h1);
        chk("R5 irq dropped", {31'b0, irq}, 32'h0);
        rchk("R11 fiq status read", 12'h88, 32'h1);
        lines[0] = 1'b0;
        tick();
        rchk("R6 level raw drops", 12'h90, 32'h0);
    endtask

    task automatic t_select_half();
        clean();
        wr(12'h98, 32'h0000_0005);
        wr(12'h9C, 32'hFFFF_FFFF);
        rchk("R5 high select", 12'h9C, 32'h0007_FFFF);
        rchk("R5 low select kept", 12'h98, 32'h0000_0005);
    endtask

    task automatic t_edge1();
        clean();
        lines[46] = 1'b1; tick();
        lines[46] = 1'b0; tick();
        rchk("R7 rising edge sticky", 12'h94, 32'h0000_4000);
        lines[45] = 1'b1; tick();
        rchk("R7 falling line ignores rise", 12'h94, 32'h0000_4000);
        lines[45] = 1'b0; tick();
        rchk("R7 falling edge set", 12'h94, 32'h0000_6000);
        rchk("R9 edge status high", 12'hE4, 32'h0000_6000);
    endtask

    task automatic t_dual();
        clean();
        lines[16] = 1'b1; tick();
        rchk("R8 dual rise", 12'h90, 32'h0001_0000);
        wr(12'hD8, 32'h0001_0000);
        rchk("R9 edge clear", 12'h90, 32'h0);
        lines[16] = 1'b0; tick();
        rchk("R8 dual fall", 12'h90, 32'h0001_0000);
    endtask

    task automatic t_race();
        clean();
        lines[46] = 1'b1; tick();
        lines[46] = 1'b0; tick();
        wr(12'hDC, 32'h0000_4000);
        rchk("R9 clear edge line", 12'h94, 32'h0);
        lines[46] = 1'b1; tick();
        lines[46] = 1'b0; tick();
        lines[46] = 1'b1;
        wr(12'hDC, 32'h0000_4000);
        rchk("R9 edge wins over clear", 12'h94, 32'h0000_4000);
        wr(12'hDC, 32'h0000_4000);
        rchk("R9 clear without edge", 12'h94, 32'h0);
        lines[46] = 1'b0;
    endtask

    task automatic t_polarity();
        clean();
        wr(12'hD0, 32'h0);
        rchk("R10 low write ignored", 12'hD0, 32'hFFF8_FFFF);
        wr(12'hD4, 32'hFFFF_FFFF);
        rchk("R10 only 47..50 written", 12'hD4, 32'h0007_DF07);
        wr(12'hD4, 32'h0000_8000);
        rchk("R10 bits overwritten", 12'hD4, 32'h0000_DF07);
        lines[47] = 1'b1; tick();
        rchk("R10 line 47 now rising", 12'h94, 32'h0000_8000);
        wr(12'hDC, 32'h0000_8000);
        lines[47] = 1'b0; tick();
        rchk("R10 fall ignored after change", 12'h94, 32'h0);
    endtask

    task automatic t_space();
        clean();
        wr(12'h020, 32'hFFFF_FFFF);
        rchk("R3 legacy write no effect", 12'hA0, 32'h0);
        wr(12'hA0, 32'h0000_0003);
        rchk("R3 legacy read zero", 12'h020, 32'h0);
        rchk("R12 write-only reads zero", 12'hA8, 32'h0);
        wr(12'hB0, 32'hFFFF_FFFF);
        rchk("R12 sw word reads zero", 12'hB0, 32'h0);
        rchk("R12 sw write no raw", 12'h90, 32'h0);
        wr(12'hC0, 32'h0);
        rchk("R12 sense write ignored", 12'hC0, 32'hFFF8_FFFF);
        wr(12'hF0, 32'hFFFF_FFFF);
        rchk("R12 undefined reads zero", 12'hF0, 32'h0);
        rchk("R12 enable intact", 12'hA0, 32'h0000_0003);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_enable_split();
        t_level();
        t_select_half();
        t_edge1();
        t_dual();
        t_race();
        t_polarity();
        t_space();
        finish_run();
    end

endmodule